// File: doc/BRIEF.md
# Three-Channel Programmable Interval Timer

This block holds three independent 16-bit down-counting timer channels behind a byte-wide register bus. A free-running tick enable, nominally 1193182 pulses per second, advances all channels. Software picks a channel's counting behaviour and byte access pattern through a command register. It loads a reload value one byte at a time and reads back either the live count or a frozen snapshot, again one byte at a time.

Each channel counts in one of five behaviours: an interrupt on terminal count, a one-shot, a rate generator, a square wave or a software strobe. Channel 0 raises a one-clock interrupt request whenever it signals an output event. An auxiliary register gates channel 2 and reads back its output pin. Channel 2 is typically used as a tone source.

Top module: `prog_interval_timer`

## Requirements
- R1: Bus offset 0, 1 and 2 address the data ports of channels 0, 1 and 2. Offset 3 is the write-only command port and offset 4 is the auxiliary register. Reads of offset 3 and of offsets 5 to 7 return 0. A command byte carries the channel in bits 7:6, the access mode in bits 5:4 and the counting mode in bits 3:1. Bit 0 is ignored, and a channel field of 3 makes the whole byte ignored.
- R2: After reset every channel is idle, with reload, count, latch and output at 0 and its read pointer on the low byte. Its access mode is the latch code, so data writes are ignored until a command with a nonzero access mode arrives. The interrupt and the read data are 0.
- R3: A command with access mode 0 copies the live count into the channel's latch only if no latch is held, and changes nothing else. A held latch is released once its high byte has been read.
- R4: Data reads alternate low byte then high byte, starting low. They return the latch when one is held and the live count otherwise. Read data appears on the clock edge that takes the read.
- R5: Access mode 1 writes the reload's low byte and access mode 2 its high byte; each such write is final. Access mode 3 takes the low byte, then the high byte, which is final, and then returns to the low byte.
- R6: A command with a nonzero access mode stores the access mode and the counting mode, with codes 5, 6 and 7 folded to 4, 2 and 3. It makes the channel idle. It drives the output low for modes 0 and 1 and high for modes 2, 3 and 4.
- R7: A final byte makes the channel pending, unless it is already running in mode 2. On the next tick a pending channel loads its reload value and starts running, with no count that tick. In mode 3 the value is rounded down to even. A loaded value of 0 stands for 65536 counts.
- R8: Each tick takes one from a running channel's count, or two in mode 3. Terminal count is reached on the tick where the count, before it is decremented, is no larger than the step.
- R9: At terminal count in mode 0 the channel stops with count 0. If its output is low, the output goes high and an output event is signalled. In mode 4 the channel stops with count 0 and leaves its output alone.
- R10: In mode 2 every terminal count reloads the counter and signals an event. A final byte written while mode 2 is running leaves it running, and the new value takes effect at the next reload.
- R11: In mode 3 terminal count toggles the output and reloads the even-rounded value, with an event when the output turns high. In mode 1 terminal count reloads, and it drives a low output high with an event.
- R12: The interrupt output is high for exactly the clock after the edge that processes a channel 0 tick producing an event.
- R13: Writing the auxiliary register stores every bit except bit 5, which reads as channel 2's output while bit 0 is set and as 0 otherwise. Channel 2 takes ticks only while bit 0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable, one pulse per timer period |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, registered |
| irq | output | 1 | Channel 0 interrupt pulse |
| ch_out | output | 3 | Output pin of each channel |

## Verification
On every cycle, the embedded properties check several invariants. An output event only comes from a channel that was running. A latch is dropped only by a high-byte read. A mode 3 count is even right after loading. A running rate generator survives a reload write, and a real command leaves the channel idle. The bench's scenarios are needed for the rest: the exact tick counts between events (including the 65536-count case for a zero reload), the byte ordering of loads and reads, the deferred rate-generator reload, and the gating of channel 2. A reference model in the bench checks these against long random sequences of commands, ticks and accesses.

// File: rtl/pit_pkg.sv
package pit_pkg;

  typedef enum logic [1:0] {
    RUN_IDLE = 2'd0,
    RUN_PEND = 2'd1,
    RUN_ACT  = 2'd2
  } run_e;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    MD_TCINT   = 3'd0,
    MD_ONESHOT = 3'd1,
    MD_RATE    = 3'd2,
    MD_SQUARE  = 3'd3,
    MD_STROBE  = 3'd4
  } mode_e;

  // Codes above 4 alias onto supported behaviours.
  function automatic mode_e fold_mode(input logic [2:0] code);
    case (code)
      3'd0:    fold_mode = MD_TCINT;
      3'd1:    fold_mode = MD_ONESHOT;
      3'd2:    fold_mode = MD_RATE;
      3'd3:    fold_mode = MD_SQUARE;
      3'd6:    fold_mode = MD_RATE;
      3'd7:    fold_mode = MD_SQUARE;
      default: fold_mode = MD_STROBE;
    endcase
  endfunction

endpackage

// File: rtl/pit_cmd_dec.sv
module pit_cmd_dec
  import pit_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int BYTE_W = 8
) (
  input  logic              we,
  input  logic [BYTE_W-1:0] din,
  output logic [NUM_CH-1:0] ch_we,
  output acc_e              acc,
  output logic [2:0]        mode
);
  localparam int SEL_LSB = BYTE_W - 2;

  logic unused_bcd;
  assign unused_bcd = din[0];

  assign acc  = acc_e'(din[SEL_LSB-1 -: 2]);
  assign mode = din[3:1];

  // channel field value 3 matches no channel and is dropped
  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign ch_we[i] = we && (din[BYTE_W-1:SEL_LSB] == 2'(i));
  end
endmodule

// File: rtl/pit_aux_reg.sv
module pit_aux_reg #(
  parameter int BYTE_W   = 8,
  parameter int GATE_BIT = 0,
  parameter int OUT_BIT  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [BYTE_W-1:0] din,
  input  logic              out_pin,
  output logic [BYTE_W-1:0] rd_val,
  output logic              gate
);
  localparam logic [BYTE_W-1:0] OUT_MASK = BYTE_W'(1) << OUT_BIT;

  logic [BYTE_W-1:0] aux_q;

  always_ff @(posedge clk) begin
    if (rst)     aux_q <= '0;
    else if (we) aux_q <= din & ~OUT_MASK;
  end

  assign gate   = aux_q[GATE_BIT];
  assign rd_val = aux_q | ((aux_q[GATE_BIT] && out_pin) ? OUT_MASK : '0);

  // R13: a stored write never carries the readback bit
  a_r13_outbit_dropped: assert property (@(posedge clk) disable iff (rst)
    we |=> !aux_q[OUT_BIT]);
endmodule

// File: rtl/pit_channel.sv
module pit_channel
  import pit_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_en,
  input  logic              cmd_we,
  input  acc_e              cmd_acc,
  input  logic [2:0]        cmd_mode,
  input  logic              data_we,
  input  logic              data_re,
  input  logic [BYTE_W-1:0] data_in,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              out_pin,
  output logic              evt
);
  run_e              run_q;
  mode_e             mode_q;
  acc_e              acc_q;
  logic              wr_hi_q, rd_hi_q, latched_q, out_q, evt_q;
  logic [CNT_W-1:0]  latch_q, reload_q, count_q;

  logic [CNT_W:0]    eff_cnt, step_w;
  logic              at_tc, last_byte, keep_running;
  logic [CNT_W-1:0]  reload_even, load_val, rd_src;
  mode_e             new_mode;

  assign new_mode     = fold_mode(cmd_mode);
  assign eff_cnt      = (count_q == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, count_q};
  assign step_w       = (mode_q == MD_SQUARE) ? (CNT_W+1)'(2) : (CNT_W+1)'(1);
  assign at_tc        = (eff_cnt <= step_w);
  assign reload_even  = {reload_q[CNT_W-1:1], 1'b0};
  assign load_val     = (mode_q == MD_SQUARE) ? reload_even : reload_q;
  assign last_byte    = (acc_q == ACC_LO) || (acc_q == ACC_HI) ||
                        ((acc_q == ACC_WORD) && wr_hi_q);
  assign keep_running = (mode_q == MD_RATE) && (run_q == RUN_ACT);
  assign rd_src       = latched_q ? latch_q : count_q;
  assign rd_byte      = rd_hi_q ? rd_src[CNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
  assign out_pin      = out_q;
  assign evt          = evt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= RUN_IDLE;
      mode_q    <= MD_TCINT;
      acc_q     <= ACC_LATCH;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      latched_q <= 1'b0;
      latch_q   <= '0;
      reload_q  <= '0;
      count_q   <= '0;
      out_q     <= 1'b0;
      evt_q     <= 1'b0;
    end else begin
      evt_q <= 1'b0;
      if (cmd_we) begin
        if (cmd_acc == ACC_LATCH) begin
          if (!latched_q) begin
            latch_q   <= count_q;
            latched_q <= 1'b1;
          end
        end else begin
          mode_q  <= new_mode;
          acc_q   <= cmd_acc;
          wr_hi_q <= (cmd_acc == ACC_HI);
          run_q   <= RUN_IDLE;
          out_q   <= !((new_mode == MD_TCINT) || (new_mode == MD_ONESHOT));
        end
      end else if (data_we) begin
        case (acc_q)
          ACC_LO: reload_q[BYTE_W-1:0]     <= data_in;
          ACC_HI: reload_q[CNT_W-1:BYTE_W] <= data_in;
          ACC_WORD: begin
            if (wr_hi_q) reload_q[CNT_W-1:BYTE_W] <= data_in;
            else         reload_q[BYTE_W-1:0]     <= data_in;
            wr_hi_q <= !wr_hi_q;
          end
          default: ;
        endcase
        if (last_byte && !keep_running) run_q <= RUN_PEND;
      end else if (tick_en) begin
        if (run_q == RUN_PEND) begin
          count_q <= load_val;
          run_q   <= RUN_ACT;
        end else if (run_q == RUN_ACT) begin
          if (at_tc) begin
            case (mode_q)
              MD_TCINT: begin
                run_q   <= RUN_IDLE;
                count_q <= '0;
                if (!out_q) begin
                  out_q <= 1'b1;
                  evt_q <= 1'b1;
                end
              end
              MD_ONESHOT: begin
                count_q <= reload_q;
                if (!out_q) begin
                  out_q <= 1'b1;
                  evt_q <= 1'b1;
                end
              end
              MD_RATE: begin
                count_q <= reload_q;
                evt_q   <= 1'b1;
              end
              MD_SQUARE: begin
                count_q <= reload_even;
                out_q   <= !out_q;
                evt_q   <= !out_q;
              end
              default: begin
                run_q   <= RUN_IDLE;
                count_q <= '0;
              end
            endcase
          end else begin
            count_q <= count_q - step_w[CNT_W-1:0];
          end
        end
      end
      if (data_re) begin
        rd_hi_q <= !rd_hi_q;
        if (rd_hi_q && latched_q) latched_q <= 1'b0;
      end
    end
  end

  // R9: output events come only from a channel that was counting
  a_r9_evt_from_running: assert property (@(posedge clk) disable iff (rst)
    evt_q |-> ($past(run_q) == RUN_ACT));

  // R3: the latch is dropped only by reading its high byte
  a_r3_latch_release: assert property (@(posedge clk) disable iff (rst)
    $fell(latched_q) |-> $past(data_re && rd_hi_q));

  // R7: a square-wave load is even
  a_r7_square_even_load: assert property (@(posedge clk) disable iff (rst)
    ((run_q == RUN_ACT) && (mode_q == MD_SQUARE) && ($past(run_q) == RUN_PEND))
      |-> !count_q[0]);

  // R10: a running rate generator keeps counting across a reload write
  a_r10_rate_defer: assert property (@(posedge clk) disable iff (rst)
    ((run_q == RUN_ACT) && (mode_q == MD_RATE) && data_we && !cmd_we)
      |=> (run_q == RUN_ACT));

  // R6: a real command leaves the channel idle
  a_r6_cmd_idles: assert property (@(posedge clk) disable iff (rst)
    (cmd_we && (cmd_acc != ACC_LATCH)) |=> (run_q == RUN_IDLE));
endmodule

// File: rtl/prog_interval_timer.sv
module prog_interval_timer
  import pit_pkg::*;
#(
  parameter int CNT_W    = 16,
  parameter int ADDR_W   = 3,
  parameter int CMD_ADDR = 3,
  parameter int AUX_ADDR = 4,
  parameter int GATE_BIT = 0,
  parameter int OUT_BIT  = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        bus_en,
  input  logic        bus_we,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic        irq,
  output logic [2:0]  ch_out
);
  localparam int NUM_CH = 3;
  localparam int BYTE_W = 8;
  localparam int IRQ_CH = 0;
  localparam int AUX_CH = NUM_CH - 1;

  logic              wr_cyc, rd_cyc;
  logic [NUM_CH-1:0] cmd_ch_we, ch_evt, ch_tick;
  acc_e              cmd_acc;
  logic [2:0]        cmd_mode;
  logic [BYTE_W-1:0] ch_byte [NUM_CH];
  logic [BYTE_W-1:0] aux_rd;
  logic              aux_gate;
  logic [BYTE_W-1:0] rdata_q;

  assign wr_cyc = bus_en && bus_we;
  assign rd_cyc = bus_en && !bus_we;

  pit_cmd_dec #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) u_dec (
    .we    (wr_cyc && (bus_addr == ADDR_W'(CMD_ADDR))),
    .din   (bus_wdata),
    .ch_we (cmd_ch_we),
    .acc   (cmd_acc),
    .mode  (cmd_mode)
  );

  pit_aux_reg #(.BYTE_W(BYTE_W), .GATE_BIT(GATE_BIT), .OUT_BIT(OUT_BIT)) u_aux (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_cyc && (bus_addr == ADDR_W'(AUX_ADDR))),
    .din     (bus_wdata),
    .out_pin (ch_out[AUX_CH]),
    .rd_val  (aux_rd),
    .gate    (aux_gate)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i == AUX_CH) begin : g_gated
      assign ch_tick[i] = tick && aux_gate;
    end else begin : g_free
      assign ch_tick[i] = tick;
    end

    pit_channel #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .tick_en  (ch_tick[i]),
      .cmd_we   (cmd_ch_we[i]),
      .cmd_acc  (cmd_acc),
      .cmd_mode (cmd_mode),
      .data_we  (wr_cyc && (bus_addr == ADDR_W'(i))),
      .data_re  (rd_cyc && (bus_addr == ADDR_W'(i))),
      .data_in  (bus_wdata),
      .rd_byte  (ch_byte[i]),
      .out_pin  (ch_out[i]),
      .evt      (ch_evt[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (rd_cyc) begin
      if (bus_addr < ADDR_W'(NUM_CH))          rdata_q <= ch_byte[bus_addr[1:0]];
      else if (bus_addr == ADDR_W'(AUX_ADDR))  rdata_q <= aux_rd;
      else                                     rdata_q <= '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = ch_evt[IRQ_CH];
endmodule

// File: tb/prog_interval_timer_bench.sv
`timescale 1ns/1ps
module prog_interval_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0, bus_en = 1'b0, bus_we = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq;
  logic [2:0] ch_out;

  always #2.5 clk = !clk;

  prog_interval_timer u_prog_interval_timer (
    .clk(clk), .rst(rst), .tick(tick), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .ch_out(ch_out)
  );

  int n_vec = 0, n_bad = 0;
  bit finished = 0;
  string cur_req = "R2";

  // reference model state
  int m_run[3], m_mode[3], m_acc[3], m_wrhi[3], m_rdhi[3];
  int m_lat[3], m_latv[3], m_rel[3], m_cnt[3], m_out[3];
  int m_aux, m_evt0, m_rd;

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  function automatic int fold(input int c);
    if (c == 5) return 4;
    if (c == 6) return 2;
    if (c == 7) return 3;
    return c;
  endfunction

  function automatic void mdl_reset();
    for (int c = 0; c < 3; c++) begin
      m_run[c] = 0; m_mode[c] = 0; m_acc[c] = 0; m_wrhi[c] = 0; m_rdhi[c] = 0;
      m_lat[c] = 0; m_latv[c] = 0; m_rel[c] = 0; m_cnt[c] = 0; m_out[c] = 0;
    end
    m_aux = 0; m_evt0 = 0; m_rd = 0;
  endfunction

  function automatic void mdl_tick();
    for (int c = 0; c < 3; c++) begin
      int eff, step;
      if (c == 2 && (m_aux & 1) == 0) continue;
      if (m_run[c] == 1) begin
        m_cnt[c] = (m_mode[c] == 3) ? (m_rel[c] & 'hFFFE) : m_rel[c];
        m_run[c] = 2;
      end else if (m_run[c] == 2) begin
        eff  = (m_cnt[c] == 0) ? 65536 : m_cnt[c];
        step = (m_mode[c] == 3) ? 2 : 1;
        if (eff <= step) begin
          case (m_mode[c])
            0: begin m_run[c] = 0; m_cnt[c] = 0;
                 if (m_out[c] == 0) begin m_out[c] = 1; if (c == 0) m_evt0 = 1; end end
            1: begin m_cnt[c] = m_rel[c];
                 if (m_out[c] == 0) begin m_out[c] = 1; if (c == 0) m_evt0 = 1; end end
            2: begin m_cnt[c] = m_rel[c]; if (c == 0) m_evt0 = 1; end
            3: begin m_cnt[c] = m_rel[c] & 'hFFFE; m_out[c] = 1 - m_out[c];
                 if (m_out[c] == 1 && c == 0) m_evt0 = 1; end
            default: begin m_run[c] = 0; m_cnt[c] = 0; end
          endcase
        end else begin
          m_cnt[c] = (m_cnt[c] - step) & 'hFFFF;
        end
      end
    end
  endfunction

  function automatic void mdl_write(input int a, input int d);
    if (a < 3) begin
      int fin = 0;
      if (m_acc[a] == 0) return;
      if (m_acc[a] == 1) begin m_rel[a] = (m_rel[a] & 'hFF00) | d; fin = 1; end
      else if (m_acc[a] == 2) begin m_rel[a] = (m_rel[a] & 'hFF) | (d << 8); fin = 1; end
      else if (m_wrhi[a] == 0) begin m_rel[a] = (m_rel[a] & 'hFF00) | d; m_wrhi[a] = 1; end
      else begin m_rel[a] = (m_rel[a] & 'hFF) | (d << 8); m_wrhi[a] = 0; fin = 1; end
      if (fin && !(m_mode[a] == 2 && m_run[a] == 2)) m_run[a] = 1;
    end else if (a == 3) begin
      int sel = (d >> 6) & 3, acc = (d >> 4) & 3, md = fold((d >> 1) & 7);
      if (sel == 3) return;
      if (acc == 0) begin
        if (m_lat[sel] == 0) begin m_latv[sel] = m_cnt[sel]; m_lat[sel] = 1; end
      end else begin
        m_mode[sel] = md; m_acc[sel] = acc; m_wrhi[sel] = (acc == 2);
        m_run[sel] = 0; m_out[sel] = (md <= 1) ? 0 : 1;
      end
    end else if (a == 4) begin
      m_aux = d & 'hDF;
    end
  endfunction

  function automatic void mdl_read(input int a);
    if (a < 3) begin
      int src = m_lat[a] ? m_latv[a] : m_cnt[a];
      m_rd = m_rdhi[a] ? ((src >> 8) & 'hFF) : (src & 'hFF);
      if (m_rdhi[a] && m_lat[a]) m_lat[a] = 0;
      m_rdhi[a] = 1 - m_rdhi[a];
    end else if (a == 4) begin
      m_rd = m_aux | (((m_aux & 1) && m_out[2]) ? 32 : 0);
    end else begin
      m_rd = 0;
    end
  endfunction

  // one clock: drive at a falling edge, compare at the next falling edge
  task automatic cyc(input bit t, input bit en, input bit we, input int a, input int d);
    tick = t; bus_en = en; bus_we = we; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    m_evt0 = 0;
    if (t) mdl_tick();
    if (en && we) mdl_write(a, d);
    if (en && !we) mdl_read(a);
    tick = 0; bus_en = 0; bus_we = 0;
    chk({cur_req, " R12 irq"}, int'(irq), m_evt0);
    chk({cur_req, " output pins"}, int'(ch_out), m_out[2] * 4 + m_out[1] * 2 + m_out[0]);
    if (en && !we) chk({cur_req, " R4 read data"}, int'(bus_rdata), m_rd);
  endtask

  task automatic wr(input int a, input int d); cyc(0, 1, 1, a, d); endtask
  task automatic rd(input int a); cyc(0, 1, 0, a, 0); endtask
  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0);
  endtask
  task automatic ticks_to_irq(input int limit, output int n);
    n = 0;
    for (int i = 0; i < limit; i++) begin
      cyc(1, 0, 0, 0, 0);
      n++;
      if (irq) break;
    end
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual=running expected=done");
      summary();
    end
  end

  initial begin
    int n, sd;
    sd = $urandom(32'd2024);
    mdl_reset();
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // R2: reset state and ignored data writes before any command
    cur_req = "R2";
    chk("R2 reset irq", int'(irq), 0);
    chk("R2 reset pins", int'(ch_out), 0);
    chk("R2 reset rdata", int'(bus_rdata), 0);
    wr(0, 7); ticks(3);
    rd(0); chk("R2 write ignored lo", int'(bus_rdata), 0);
    rd(0); chk("R2 write ignored hi", int'(bus_rdata), 0);

    // R7 R8 R3 R4 R9 on channel 1, mode 0
    cur_req = "R7";
    wr(3, 'h70); wr(1, 'h0A); wr(1, 'h00); ticks(1);
    rd(1); chk("R7 loaded lo", int'(bus_rdata), 10);
    rd(1); chk("R7 loaded hi", int'(bus_rdata), 0);
    cur_req = "R8";
    ticks(3);
    rd(1); chk("R8 count lo", int'(bus_rdata), 7);
    rd(1);
    cur_req = "R3";
    wr(3, 'h40); ticks(2); wr(3, 'h40);
    rd(1); chk("R3 latched lo", int'(bus_rdata), 7);
    rd(1); chk("R3 latched hi", int'(bus_rdata), 0);
    rd(1); chk("R4 live lo after release", int'(bus_rdata), 5);
    rd(1);
    cur_req = "R9";
    ticks(4); chk("R9 before terminal", int'(ch_out[1]), 0);
    ticks(1); chk("R9 output high at terminal", int'(ch_out[1]), 1);
    rd(1); chk("R9 stopped count", int'(bus_rdata), 0);
    rd(1);

    // R5 byte access modes
    cur_req = "R5";
    wr(3, 'h50); wr(1, 'h03); ticks(1);
    rd(1); chk("R5 low-only write", int'(bus_rdata), 3);
    rd(1); chk("R5 low-only hi kept", int'(bus_rdata), 0);
    wr(3, 'h60); wr(1, 'h01); ticks(1);
    rd(1); chk("R5 high-only lo kept", int'(bus_rdata), 3);
    rd(1); chk("R5 high-only write", int'(bus_rdata), 1);

    // R10 R12 rate generator on channel 0 with deferred reload
    cur_req = "R10";
    wr(3, 'h34); wr(0, 3); wr(0, 0); ticks(1);
    ticks_to_irq(20, n); chk("R12 first event after 3 ticks", n, 3);
    wr(0, 5); wr(0, 0);
    ticks_to_irq(20, n); chk("R10 old period kept", n, 3);
    ticks_to_irq(20, n); chk("R10 new period used", n, 5);

    // R13 R11 square wave on channel 2 behind the gate
    cur_req = "R13";
    wr(4, 'h21);
    rd(4); chk("R13 bit5 not stored", int'(bus_rdata), 'h01);
    wr(3, 'hB6);
    rd(4); chk("R13 out readback", int'(bus_rdata), 'h21);
    cur_req = "R11";
    wr(2, 5); wr(2, 0); ticks(1);
    ticks(2); chk("R11 square toggles low", int'(ch_out[2]), 0);
    ticks(2); chk("R11 square toggles high", int'(ch_out[2]), 1);
    cur_req = "R13";
    wr(4, 'h00);
    rd(2); chk("R13 even reload", int'(bus_rdata), 4);
    ticks(5);
    rd(2); chk("R13 gated hi", int'(bus_rdata), 0);
    rd(2); chk("R13 gated count held", int'(bus_rdata), 4);
    rd(4); chk("R13 readback off when ungated", int'(bus_rdata), 0);

    // R7 zero reload means 65536
    cur_req = "R7";
    wr(3, 'h34); wr(0, 0); wr(0, 0); ticks(1);
    ticks_to_irq(70000, n); chk("R7 zero reload period", n, 65536);

    // R1 address map and ignored channel field
    cur_req = "R1";
    wr(3, 'hF6); rd(0); rd(0);
    rd(3); chk("R1 command port reads 0", int'(bus_rdata), 0);
    rd(6); chk("R1 unused offset reads 0", int'(bus_rdata), 0);

    // R6 mode folding and output level, R9 strobe
    cur_req = "R6";
    wr(3, 'h1C); chk("R6 code 6 output high", int'(ch_out[0]), 1);
    wr(3, 'h1A); wr(0, 2); ticks(3);
    cur_req = "R9";
    rd(0); chk("R9 strobe stops at 0", int'(bus_rdata), 0);
    rd(0);
    chk("R9 strobe output unchanged", int'(ch_out[0]), 1);
    cur_req = "R6";
    wr(3, 'h10); chk("R6 mode 0 output low", int'(ch_out[0]), 0);

    // R11 one-shot on channel 1
    cur_req = "R11";
    wr(3, 'h72); chk("R11 one-shot starts low", int'(ch_out[1]), 0);
    wr(1, 2); wr(1, 0); ticks(1);
    ticks(1); chk("R11 one-shot still low", int'(ch_out[1]), 0);
    ticks(1); chk("R11 one-shot fires", int'(ch_out[1]), 1);
    ticks(4); chk("R11 one-shot stays high", int'(ch_out[1]), 1);

    // mixed random traffic against the model
    cur_req = "R4 random";
    for (int i = 0; i < 4000; i++) begin
      int r = $urandom % 100;
      int dat = ($urandom % 5 == 0) ? ($urandom % 256) : ($urandom % 12);
      if (r < 55)      cyc(1, 0, 0, 0, 0);
      else if (r < 70) wr($urandom % 3, dat);
      else if (r < 82) rd(($urandom % 2) ? ($urandom % 3) : ($urandom % 8));
      else if (r < 90) wr(3, $urandom % 256);
      else if (r < 94) wr(4, ($urandom % 256) | (($urandom % 4 != 0) ? 1 : 0));
      else             cyc(0, 0, 0, 0, 0);
    end

    finished = 1;
    summary();
  end
endmodule